// File: doc/BRIEF.md
# Two-Winding Microstep Sequencer

This block drives the digital inputs of two full-bridge current regulators that together turn a bipolar stepper motor. It keeps a position index within a 32-position electrical cycle. For each winding it produces a direction bit and a 3-bit current-magnitude code, plus a hint that tells the regulator which decay style to use. The magnitude codes follow a nonlinear sine-like scale. The second winding runs a quarter cycle behind the first. Each pulse on the step strobe moves the index by the amount chosen on the resolution input, in the direction chosen by the direction input.

Before moving, the index is rounded down to a multiple of the current stride. After a change of resolution the sequence therefore stays on the positions that belong to that resolution. Full steps always land where both windings carry the 70.7% code. All outputs are registered. They change only in the clock cycle after a strobe is sampled, or after a synchronous reset.

Top module: `ustep_seq`

## Requirements
- R1: Synchronous reset sets the index to 0. The next cycle shows phase 1 and code 100 on both windings, and both decay hints are 0.
- R2: Magnitude codes are 111=100%, 110=92.4%, 101=83.1%, 100=70.7%, 011=55.5%, 010=38.2%, 001=19.5%, and 000=off. At index i, winding A carries level min(f, 7), where t=(i+12) mod 16 and f=t if t<=8, otherwise f=16-t. Its phase bit is 1 (positive) when (i+12) mod 32 < 16. The phase bit has no meaning when the code is 000.
- R3: Winding B at index i shows exactly what winding A shows at index (i-8) mod 32. Whenever A's code is 000, B's code is 111.
- R4: The resolution select sets the stride: 00 full gives 8, 01 half gives 4, 10 quarter gives 2, 11 eighth gives 1.
- R5: A strobe with direction 1 adds the stride to the index, and a strobe with direction 0 subtracts it, both modulo 32. Stepping back from 0 in eighth mode reaches 31 (A at 83.1% positive).
- R6: On every strobe, the index is first rounded down to a multiple of the selected stride, and then moved.
- R7: After any strobe in full-step mode, both windings show code 100.
- R8: Outputs change only in the cycle after a strobe or a reset. Without a strobe, changes on the direction and resolution inputs have no effect on any output.
- R9: On each strobe, a winding's decay hint becomes 1 (mixed decay) when its new code is below its previous code, and 0 (slow decay) otherwise. Between strobes the hint holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_i | input | 1 | Step strobe, one pulse per step |
| dir_i | input | 1 | 1 = advance, 0 = retreat |
| res_i | input | 2 | Resolution: 00 full, 01 half, 10 quarter, 11 eighth |
| phase_a_o | output | 1 | Winding A current direction (1 = positive) |
| code_a_o | output | 3 | Winding A magnitude code |
| phase_b_o | output | 1 | Winding B current direction (1 = positive) |
| code_b_o | output | 3 | Winding B magnitude code |
| mixed_a_o | output | 1 | Winding A decay hint (1 = mixed, 0 = slow) |
| mixed_b_o | output | 1 | Winding B decay hint (1 = mixed, 0 = slow) |

## Verification
A corrupted index shows on the cycle after the next strobe. The two windings then leave the fixed quarter-cycle relation, or a full step fails to land on the 70.7% pair. A wrong stride or a missing rounding stays invisible until the strobe after a resolution change. That is why the bench mixes resolution changes into random step sequences and checks every output after each strobe. A stale decay hint appears only on strobes where the magnitude reverses its trend. Long random walks in both directions therefore pass through every peak and zero crossing.

// File: rtl/ustep_pkg.sv
package ustep_pkg;

   // Resolution select encodings (stride = 8 >> sel position)
   typedef enum logic [1:0] {
      RES_FULL    = 2'd0,
      RES_HALF    = 2'd1,
      RES_QUARTER = 2'd2,
      RES_EIGHTH  = 2'd3
   } res_e;

   // Decay hint encodings
   typedef enum logic {
      DECAY_SLOW  = 1'b0,
      DECAY_MIXED = 1'b1
   } decay_e;

endpackage

// File: rtl/ustep_index.sv
module ustep_index #(
   parameter int POS_W = 5,
   parameter int RES_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step_i,
   input  logic             dir_i,
   input  logic [RES_W-1:0] res_i,
   output logic [POS_W-1:0] idx_o,
   output logic [POS_W-1:0] idx_nxt_o
);
   localparam int MAX_SHIFT = (1 << RES_W) - 1;
   localparam logic [POS_W-1:0] ONE = POS_W'(1);

   logic [POS_W-1:0] stride;
   logic [POS_W-1:0] base;
   logic [POS_W-1:0] idx_q;
   logic [POS_W-1:0] idx_d;
   logic [RES_W-1:0] shamt;

   always_comb begin
      shamt  = RES_W'(MAX_SHIFT) - res_i;
      stride = ONE << shamt;
      base   = idx_q & ~(stride - ONE);
      if (rst)
         idx_d = '0;
      else if (step_i)
         idx_d = dir_i ? (base + stride) : (base - stride);
      else
         idx_d = idx_q;
   end

   always_ff @(posedge clk) begin
      if (rst) idx_q <= '0;
      else     idx_q <= idx_d;
   end

   assign idx_o     = idx_q;
   assign idx_nxt_o = idx_d;

   // R8
   idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !step_i |=> $stable(idx_q));

   // R6
   idx_aligned_chk: assert property (@(posedge clk) disable iff (rst)
      step_i |=> ((idx_q & ($past(stride) - ONE)) == '0));

   // R5
   idx_fine_fwd_chk: assert property (@(posedge clk) disable iff (rst)
      (step_i && dir_i && res_i == RES_W'(MAX_SHIFT)) |=> (idx_q == $past(idx_q) + ONE));

endmodule

// File: rtl/ustep_profile.sv
module ustep_profile #(
   parameter int POS_W  = 5,
   parameter int CODE_W = 3,
   parameter int OFFSET = 0
) (
   input  logic [POS_W-1:0]  idx_i,
   output logic              phase_o,
   output logic [CODE_W-1:0] code_o
);
   localparam int POSITIONS = 1 << POS_W;
   localparam int QUARTER   = POSITIONS / 4;
   localparam int HALF      = POSITIONS / 2;
   localparam int SHIFT     = (QUARTER + QUARTER / 2 + OFFSET) % POSITIONS;
   localparam logic [POS_W-1:0] SHIFT_V = POS_W'(SHIFT);
   localparam logic [POS_W-1:0] QV      = POS_W'(QUARTER);
   localparam logic [POS_W-1:0] HV      = POS_W'(HALF);
   localparam logic [POS_W-1:0] MAXV    = POS_W'((1 << CODE_W) - 1);

   logic [POS_W-1:0] u;
   logic [POS_W-1:0] t;
   logic [POS_W-1:0] fold;

   always_comb begin
      u    = idx_i + SHIFT_V;
      t    = {1'b0, u[POS_W-2:0]};
      fold = (t <= QV) ? t : (HV - t);
      code_o  = (fold > MAXV) ? MAXV[CODE_W-1:0] : fold[CODE_W-1:0];
      phase_o = ~u[POS_W-1];
   end

endmodule

// File: rtl/ustep_winding.sv
module ustep_winding #(
   parameter int POS_W  = 5,
   parameter int CODE_W = 3,
   parameter int OFFSET = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step_i,
   input  logic [POS_W-1:0]  idx_nxt_i,
   output logic              phase_o,
   output logic [CODE_W-1:0] code_o,
   output logic              mixed_o
);
   logic              phase_n;
   logic [CODE_W-1:0] code_n;
   logic              phase_q;
   logic [CODE_W-1:0] code_q;
   logic              mixed_q;

   ustep_profile #(
      .POS_W (POS_W),
      .CODE_W(CODE_W),
      .OFFSET(OFFSET)
   ) u_profile (
      .idx_i  (idx_nxt_i),
      .phase_o(phase_n),
      .code_o (code_n)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= phase_n;
         code_q  <= code_n;
         mixed_q <= ustep_pkg::DECAY_SLOW;
      end else if (step_i) begin
         phase_q <= phase_n;
         code_q  <= code_n;
         mixed_q <= (code_n < code_q) ? ustep_pkg::DECAY_MIXED : ustep_pkg::DECAY_SLOW;
      end
   end

   assign phase_o = phase_q;
   assign code_o  = code_q;
   assign mixed_o = mixed_q;

   // R8
   out_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !step_i |=> ($stable(code_q) && $stable(phase_q) && $stable(mixed_q)));

endmodule

// File: rtl/ustep_seq.sv
module ustep_seq #(
   parameter int POS_W  = 5,
   parameter int RES_W  = 2,
   parameter int CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step_i,
   input  logic              dir_i,
   input  logic [RES_W-1:0]  res_i,
   output logic              phase_a_o,
   output logic [CODE_W-1:0] code_a_o,
   output logic              phase_b_o,
   output logic [CODE_W-1:0] code_b_o,
   output logic              mixed_a_o,
   output logic              mixed_b_o
);
   localparam int POSITIONS = 1 << POS_W;
   localparam int QUARTER   = POSITIONS / 4;
   localparam int WINDINGS  = 2;
   localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);
   localparam logic [CODE_W-1:0] TOP_CODE = '1;

   generate
      if (POS_W - 2 != (1 << RES_W) - 1) begin : g_bad_res
         $error("ustep_seq: full stride must equal a quarter cycle");
      end
      if (CODE_W != POS_W - 2) begin : g_bad_code
         $error("ustep_seq: code width must match the quarter-cycle level count");
      end
   endgenerate

   logic [POS_W-1:0]  idx_q;
   logic [POS_W-1:0]  idx_nxt;
   logic              phase_w [WINDINGS];
   logic [CODE_W-1:0] code_w  [WINDINGS];
   logic              mixed_w [WINDINGS];

   ustep_index #(
      .POS_W(POS_W),
      .RES_W(RES_W)
   ) u_index (
      .clk      (clk),
      .rst      (rst),
      .step_i   (step_i),
      .dir_i    (dir_i),
      .res_i    (res_i),
      .idx_o    (idx_q),
      .idx_nxt_o(idx_nxt)
   );

   generate
      for (genvar w = 0; w < WINDINGS; w++) begin : g_wind
         ustep_winding #(
            .POS_W (POS_W),
            .CODE_W(CODE_W),
            .OFFSET((POSITIONS - w * QUARTER) % POSITIONS)
         ) u_wind (
            .clk      (clk),
            .rst      (rst),
            .step_i   (step_i),
            .idx_nxt_i(idx_nxt),
            .phase_o  (phase_w[w]),
            .code_o   (code_w[w]),
            .mixed_o  (mixed_w[w])
         );
      end
   endgenerate

   assign phase_a_o = phase_w[0];
   assign code_a_o  = code_w[0];
   assign mixed_a_o = mixed_w[0];
   assign phase_b_o = phase_w[1];
   assign code_b_o  = code_w[1];
   assign mixed_b_o = mixed_w[1];

   // R7
   full_pair_chk: assert property (@(posedge clk) disable iff (rst)
      (step_i && res_i == RES_W'(ustep_pkg::RES_FULL)) |=> (code_a_o == MID_CODE && code_b_o == MID_CODE));

   // R3
   off_peak_chk: assert property (@(posedge clk) disable iff (rst)
      (code_a_o == '0) |-> (code_b_o == TOP_CODE));

endmodule

// File: tb/ustep_seq_tb.sv
module ustep_seq_tb;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic       rst, step, dir;
   logic [1:0] res;
   logic       phase_a, phase_b, mixed_a, mixed_b;
   logic [2:0] code_a, code_b;

   int checks = 0;
   int fails  = 0;
   int idx_m  = 0;
   bit mix_a_m = 0, mix_b_m = 0;
   bit done = 0;

   ustep_seq u_dut (
      .clk(clk), .rst(rst), .step_i(step), .dir_i(dir), .res_i(res),
      .phase_a_o(phase_a), .code_a_o(code_a),
      .phase_b_o(phase_b), .code_b_o(code_b),
      .mixed_a_o(mixed_a), .mixed_b_o(mixed_b)
   );

   function automatic int lvl(int i);
      int t = ((i + 12) % 32) % 16;
      int f = (t <= 8) ? t : 16 - t;
      return (f > 7) ? 7 : f;
   endfunction

   function automatic int ph(int i);
      return (((i + 12) % 32) < 16) ? 1 : 0;
   endfunction

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_all(string req);
      int ib = (idx_m + 24) % 32;
      check(req, "code_a", code_a, lvl(idx_m));
      if (lvl(idx_m) != 0) check(req, "phase_a", phase_a, ph(idx_m));
      check(req, "code_b", code_b, lvl(ib));
      if (lvl(ib) != 0) check(req, "phase_b", phase_b, ph(ib));
      check({req, "/R9"}, "mixed_a", mixed_a, mix_a_m);
      check({req, "/R9"}, "mixed_b", mixed_b, mix_b_m);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; step = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      idx_m = 0; mix_a_m = 0; mix_b_m = 0;
   endtask

   task automatic do_step(bit d, int r);
      int st, base, nxt;
      @(negedge clk);
      step = 1'b1; dir = d; res = r[1:0];
      st   = 1 << (3 - r);
      base = idx_m & ~(st - 1) & 31;
      nxt  = d ? (base + st) % 32 : (base - st + 32) % 32;
      mix_a_m = lvl(nxt) < lvl(idx_m);
      mix_b_m = lvl((nxt + 24) % 32) < lvl((idx_m + 24) % 32);
      idx_m = nxt;
      @(negedge clk);
      step = 1'b0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R8 watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      rst = 1'b1; step = 1'b0; dir = 1'b1; res = 2'd3;
      repeat (3) @(negedge clk);
      do_reset();
      // R1 reset state
      check("R1", "phase_a", phase_a, 1);
      check("R1", "code_a", code_a, 4);
      check("R1", "phase_b", phase_b, 1);
      check("R1", "code_b", code_b, 4);
      check("R1", "mixed_a", mixed_a, 0);
      check("R1", "mixed_b", mixed_b, 0);

      // R9 first eighth step forward: A falls, B rises
      do_step(1, 3);
      check("R9", "mixed_a", mixed_a, 1);
      check("R9", "mixed_b", mixed_b, 0);
      check("R2", "code_a", code_a, 3);
      check("R3", "code_b", code_b, 5);

      // R5 wrap backwards from 0
      do_reset();
      do_step(0, 3);
      check("R5", "code_a", code_a, 5);
      check("R5", "phase_a", phase_a, 1);
      check_all("R5");

      // R6 rounding: index 3 then a full step forward lands on 8
      do_reset();
      repeat (3) do_step(1, 3);
      do_step(1, 0);
      check("R6", "code_a", code_a, 4);
      check("R6", "phase_a", phase_a, 0);
      check("R6", "phase_b", phase_b, 1);

      // R4 half step from 0 reaches index 4: A off, B at peak
      do_reset();
      do_step(1, 1);
      check("R4", "code_a", code_a, 0);
      check("R4", "code_b", code_b, 7);

      // R7 full steps both directions
      for (int k = 0; k < 10; k++) begin
         do_step(k % 3 != 0, 0);
         check("R7", "code_a", code_a, 4);
         check("R7", "code_b", code_b, 4);
      end

      // R2 R3 full eighth-step cycle forward and back
      do_reset();
      for (int k = 0; k < 33; k++) begin
         do_step(1, 3);
         check_all("R2");
      end
      for (int k = 0; k < 33; k++) begin
         do_step(0, 3);
         check_all("R3");
      end

      // R8 idle inputs change, no strobe
      begin
         logic [2:0] ca, cb;
         logic pa, pb, ma, mb;
         ca = code_a; cb = code_b; pa = phase_a; pb = phase_b; ma = mixed_a; mb = mixed_b;
         for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            dir = k[0]; res = k[1:0];
         end
         @(negedge clk);
         check("R8", "code_a", code_a, ca);
         check("R8", "code_b", code_b, cb);
         check("R8", "phase_a", phase_a, pa);
         check("R8", "phase_b", phase_b, pb);
         check("R8", "mixed_a", mixed_a, ma);
         check("R8", "mixed_b", mixed_b, mb);
      end

      // Constrained random walk
      void'($urandom(32'h5EED_1234));
      for (int k = 0; k < 600; k++) begin
         int gap = $urandom_range(0, 3);
         repeat (gap) @(negedge clk);
         if ($urandom_range(0, 99) == 0) begin
            do_reset();
            check_all("R1");
         end else begin
            do_step($urandom_range(0, 1), $urandom_range(0, 3));
            check_all("R6");
         end
      end

      done = 1;
      finish_run();
   end
endmodule